// File: doc/BRIEF.md
# Crosspoint chain loader

This block lets host logic on a fast system clock program a chain of cascaded 16x16 analog crosspoint switch devices. The devices take their setting through a three-wire serial path: a data line, a serial clock whose rising edge shifts the data in, and an active-low commit strobe that copies the shifted bits into the switch latches. The serial output of each device feeds the serial input of the next, so the whole chain behaves as one long shift register.

On a start pulse the block captures a configuration vector holding one bit per switch for every device. It shifts all of these bits out, most significant first. Each serial clock phase lasts a programmable number of system clocks. It then waits a guard time, pulses the commit strobe low, and finishes with a one-cycle done pulse. The number of devices, the grid size, the system clock period and every phase length are parameters. Elaboration stops when the resulting timing would break the devices' limits.

Top module: `xbar_chain_loader`

## Requirements
- R1: While reset is asserted and after it is released, sclk_o is 0, pclk_no is 1, busy_o is 0 and done_o is 0.
- R2: Bit cfg_i[d*256 + y*16 + x] sets the switch at row y, column x of device d (device 0 is the one whose serial input sin_o drives; 1 closes the switch). One load produces exactly 256*N_DEV rising edges of sclk_o. The bit presented on the k-th edge is cfg_i[256*N_DEV-1-k], so the farthest device's row 15, column 15 goes first and device 0's row 0, column 0 goes last.
- R3: Each sclk_o high phase lasts exactly DIV system clocks. Between two bits sclk_o stays low for exactly DIV system clocks. sin_o is stable for at least DIV clocks before each rising edge and does not change while sclk_o is high.
- R4: After the final falling edge of sclk_o, pclk_no goes low after exactly GAP_CYC clocks and stays low for exactly PULSE_CYC clocks. sclk_o stays low while pclk_no is low.
- R5: busy_o rises in the cycle after an accepted start_i and stays high through the done cycle. done_o is high for exactly one cycle, with busy_o high, and busy_o is low in the following cycle.
- R6: A start_i seen while busy_o is high is ignored: no extra load follows. cfg_i is sampled only when start is accepted, so changing it during a load does not alter the shifted bits.
- R7: The serial clock period 2*DIV*SYS_CLK_PS lies between 200 ns and 50 us. The time from the last rising edge of sclk_o to the end of the commit pulse is below 5 ms. Parameter sets that violate these limits, or that give a gap or strobe shorter than 65 ns, are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to load the chain, accepted only when idle |
| cfg_i | input | 256*N_DEV | Switch settings for all devices |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse at the end of a load |
| sin_o | output | 1 | Serial data to the first device |
| sclk_o | output | 1 | Serial shift clock |
| pclk_no | output | 1 | Active-low commit strobe |

## Verification
On every cycle the bound checker verifies the width of each serial clock high phase and of the commit strobe. It also checks that serial data holds steady while the clock is high, that the strobe never overlaps a high serial clock, and the busy/done relationship around an accepted start. Only the bench scenarios can show that the right bits arrive in the right order, that the low phase, setup time and guard gap have their exact lengths, and that a start request or a configuration change during a load leaves the shifted stream untouched.

// File: rtl/xbar_loader_pkg.sv
package xbar_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_COMMIT,
    ST_DONE
  } ld_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/xbar_phase_timer.sv
module xbar_phase_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == len_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || last_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/xbar_shift_store.sv
module xbar_shift_store #(
  parameter int unsigned W = 512
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] cfg_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] data_q;

  assign msb_o = data_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (load_i)  data_q <= cfg_i;
    else if (shift_i) data_q <= {data_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/xbar_load_fsm.sv
module xbar_load_fsm
  import xbar_loader_pkg::*;
#(
  parameter int unsigned TOTAL     = 512,
  parameter int unsigned CW        = 6,
  parameter int unsigned DIV       = 25,
  parameter int unsigned GAP_CYC   = 20,
  parameter int unsigned PULSE_CYC = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tick_last_i,
  output logic          restart_o,
  output logic [CW-1:0] len_o,
  output logic          load_o,
  output logic          shift_o,
  output logic          sclk_o,
  output logic          pclk_no,
  output logic          busy_o,
  output logic          done_o
);
  localparam int unsigned BW = $clog2(TOTAL);
  localparam logic [BW-1:0] LAST_BIT = BW'(TOTAL - 1);

  ld_state_e     state_q;
  logic          hi_q;
  logic [BW-1:0] bit_q;
  logic          sclk_q;
  logic          pclk_q;

  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign restart_o = load_o;
  assign shift_o   = (state_q == ST_SHIFT) && tick_last_i && hi_q && (bit_q != LAST_BIT);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign sclk_o    = sclk_q;
  assign pclk_no   = pclk_q;

  always_comb begin
    unique case (state_q)
      ST_GAP:    len_o = CW'(GAP_CYC);
      ST_COMMIT: len_o = CW'(PULSE_CYC);
      default:   len_o = CW'(DIV);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hi_q    <= 1'b0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      pclk_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SHIFT;
          hi_q    <= 1'b0;
          bit_q   <= '0;
        end
        ST_SHIFT: if (tick_last_i) begin
          if (!hi_q) begin
            hi_q   <= 1'b1;
            sclk_q <= 1'b1;
          end else begin
            hi_q   <= 1'b0;
            sclk_q <= 1'b0;
            if (bit_q == LAST_BIT) state_q <= ST_GAP;
            else                   bit_q   <= bit_q + BW'(1);
          end
        end
        ST_GAP: if (tick_last_i) begin
          pclk_q  <= 1'b0;
          state_q <= ST_COMMIT;
        end
        ST_COMMIT: if (tick_last_i) begin
          pclk_q  <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbar_chain_loader.sv
module xbar_chain_loader
  import xbar_loader_pkg::*;
#(
  parameter int unsigned N_DEV      = 2,
  parameter int unsigned GRID       = 16,
  parameter int unsigned SYS_CLK_PS = 4000,
  parameter int unsigned DIV        = 25,
  parameter int unsigned GAP_CYC    = 20,
  parameter int unsigned PULSE_CYC  = 20
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [N_DEV*GRID*GRID-1:0]   cfg_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         sin_o,
  output logic                         sclk_o,
  output logic                         pclk_no
);
  localparam int unsigned TOTAL = N_DEV * GRID * GRID;
  localparam int unsigned CW    = $clog2(max3(DIV, GAP_CYC, PULSE_CYC) + 1);
  localparam longint unsigned PERIOD_PS = 64'(2) * DIV * SYS_CLK_PS;
  localparam longint unsigned TAIL_PS   = (64'(DIV) + GAP_CYC + PULSE_CYC) * SYS_CLK_PS;

  if (PERIOD_PS < 64'd200_000 || PERIOD_PS > 64'd50_000_000 ||
      TAIL_PS > 64'd5_000_000_000 ||
      64'(GAP_CYC) * SYS_CLK_PS < 64'd65_000 ||
      64'(PULSE_CYC) * SYS_CLK_PS < 64'd65_000) begin : g_bad_timing
    $error("xbar_chain_loader: serial timing parameters out of range");
  end

  logic          restart;
  logic [CW-1:0] len;
  logic          tick_last;
  logic          load;
  logic          shift;

  xbar_phase_timer #(.CW(CW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .len_i    (len),
    .last_o   (tick_last)
  );

  xbar_shift_store #(.W(TOTAL)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .cfg_i  (cfg_i),
    .shift_i(shift),
    .msb_o  (sin_o)
  );

  xbar_load_fsm #(
    .TOTAL    (TOTAL),
    .CW       (CW),
    .DIV      (DIV),
    .GAP_CYC  (GAP_CYC),
    .PULSE_CYC(PULSE_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .tick_last_i(tick_last),
    .restart_o  (restart),
    .len_o      (len),
    .load_o     (load),
    .shift_o    (shift),
    .sclk_o     (sclk_o),
    .pclk_no    (pclk_no),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/xbar_chain_loader_chk.sv
module xbar_chain_loader_chk #(
  parameter int unsigned DIV       = 25,
  parameter int unsigned PULSE_CYC = 20
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic sin_o,
  input logic sclk_o,
  input logic pclk_no
);
  int unsigned hi_len_q;
  int unsigned lo_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len_q <= 0;
      lo_len_q <= 0;
    end else begin
      hi_len_q <= sclk_o ? hi_len_q + 1 : 0;
      lo_len_q <= !pclk_no ? lo_len_q + 1 : 0;
    end
  end

  p_sclk_high_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> hi_len_q == DIV);

  p_sin_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o && $past(sclk_o) |-> $stable(sin_o));

  p_strobe_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pclk_no) |-> lo_len_q == PULSE_CYC);

  p_strobe_sclk_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pclk_no |-> !sclk_o);

  p_start_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o);

  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o ##1 !done_o && !busy_o);

  p_busy_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
endmodule

bind xbar_chain_loader xbar_chain_loader_chk #(
  .DIV      (DIV),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .sin_o  (sin_o),
  .sclk_o (sclk_o),
  .pclk_no(pclk_no)
);

// File: tb/xbar_chain_loader_test.sv
`timescale 1ns/1ps
module xbar_chain_loader_test;
  localparam int unsigned N   = 2;
  localparam int unsigned G   = 16;
  localparam int unsigned TOT = N * G * G;
  localparam int unsigned DIV = 25;
  localparam int unsigned GAP = 20;
  localparam int unsigned PUL = 20;
  localparam longint unsigned CLK_PS = 4000;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [TOT-1:0] cfg_i = '0;
  logic busy_o, done_o, sin_o, sclk_o, pclk_no;

  always #2 clk = ~clk;

  xbar_chain_loader #(
    .N_DEV(N), .GRID(G), .SYS_CLK_PS(4000), .DIV(DIV), .GAP_CYC(GAP), .PULSE_CYC(PUL)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cfg_i(cfg_i),
    .busy_o(busy_o), .done_o(done_o), .sin_o(sin_o), .sclk_o(sclk_o), .pclk_no(pclk_no)
  );

  int n_chk = 0;
  int n_fail = 0;

  // monitor state
  logic           p_sclk = 1'b0, p_pclk = 1'b1, p_sin = 1'b0, p_done = 1'b0;
  logic [TOT-1:0] got_seq;
  int nbits, hi_len, lo_len, sin_age, since_fall, since_rise, pl_len, done_len, rise_gap;
  int hi_bad, lo_bad, setup_bad, hold_bad, sclk_in_pulse, done_seen, done_bad, done_nobusy;
  int gap_meas, pulse_meas, tail_meas, per_min, per_max;

  task automatic clear_mon();
    got_seq = '0; nbits = 0; hi_bad = 0; lo_bad = 0; setup_bad = 0; hold_bad = 0;
    sclk_in_pulse = 0; done_seen = 0; done_bad = 0; done_nobusy = 0;
    gap_meas = -1; pulse_meas = -1; tail_meas = -1; per_min = 1 << 30; per_max = 0;
  endtask

  initial begin
    clear_mon();
    hi_len = 0; lo_len = 0; sin_age = 0; since_fall = 0; since_rise = 0;
    pl_len = 0; done_len = 0; rise_gap = 0;
  end

  always @(negedge clk) if (rst_ni) begin
    logic rise, fall, pf, pr;
    rise = sclk_o && !p_sclk;
    fall = !sclk_o && p_sclk;
    pf   = !pclk_no && p_pclk;
    pr   = pclk_no && !p_pclk;
    if (rise) begin
      if (nbits < TOT) got_seq[nbits] = sin_o;
      if (sin_age < DIV) setup_bad++;
      if (nbits > 0) begin
        if (lo_len != DIV) lo_bad++;
        if (rise_gap < per_min) per_min = rise_gap;
        if (rise_gap > per_max) per_max = rise_gap;
      end
      if (!pclk_no) sclk_in_pulse++;
      nbits++;
    end
    if (fall && hi_len != DIV) hi_bad++;
    if (sin_o != p_sin && sclk_o && p_sclk) hold_bad++;
    if (sclk_o && !pclk_no) sclk_in_pulse++;
    if (pf) gap_meas = since_fall;
    if (pr) begin
      pulse_meas = pl_len;
      tail_meas  = since_rise;
    end
    if (done_o && !p_done) begin
      done_seen++;
      if (!busy_o) done_nobusy++;
    end
    if (!done_o && p_done && done_len != 1) done_bad++;
    hi_len     = sclk_o ? (rise ? 1 : hi_len + 1) : 0;
    lo_len     = !sclk_o ? (fall ? 1 : lo_len + 1) : 0;
    sin_age    = (sin_o != p_sin) ? 1 : sin_age + 1;
    since_fall = fall ? 1 : since_fall + 1;
    since_rise = rise ? 1 : since_rise + 1;
    rise_gap   = rise ? 1 : rise_gap + 1;
    pl_len     = !pclk_no ? (pf ? 1 : pl_len + 1) : 0;
    done_len   = done_o ? done_len + 1 : 0;
    p_sclk = sclk_o; p_pclk = pclk_no; p_sin = sin_o; p_done = done_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [TOT-1:0] mk_pat(input logic [31:0] seed);
    logic [31:0]    s;
    logic [TOT-1:0] p;
    s = seed;
    for (int i = 0; i < TOT; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      p[i] = s[0];
    end
    return p;
  endfunction

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(sclk_o == 1'b0 && pclk_no == 1'b1, "R1", "serial lines in reset",
        {sclk_o, pclk_no}, 2'b01);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "busy/done in reset", {busy_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(sclk_o == 1'b0 && pclk_no == 1'b1 && !busy_o && !done_o, "R1", "idle after reset",
        {sclk_o, pclk_no, busy_o, done_o}, 4'b0100);
  endtask

  // one complete load with optional disturbance mid-way
  task automatic t_load(input logic [TOT-1:0] pat, input bit disturb);
    int mism, wait_cyc;
    settle();
    clear_mon();
    @(negedge clk);
    cfg_i = pat; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R5", "busy after accepted start", busy_o, 1);
    if (disturb) begin
      repeat (300) @(negedge clk);
      cfg_i = ~pat; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_cyc = 0;
    while (!done_o && wait_cyc < 60000) begin
      @(negedge clk);
      wait_cyc++;
    end
    @(negedge clk);
    chk(busy_o == 1'b0, "R5", "busy low after done", busy_o, 0);
    repeat (2) @(negedge clk);
    settle();
    chk(done_seen == 1 && done_bad == 0 && done_nobusy == 0, "R5", "single done with busy",
        done_seen, 1);
    chk(nbits == TOT, "R2", "serial clock rising edges", nbits, TOT);
    mism = 0;
    for (int k = 0; k < TOT; k++) if (got_seq[k] !== pat[TOT-1-k]) mism++;
    chk(mism == 0, disturb ? "R6" : "R2", "bits differing from captured cfg", mism, 0);
    chk(got_seq[0] === pat[TOT-1], "R2", "first bit is far device row15/col15",
        got_seq[0], pat[TOT-1]);
    chk(got_seq[TOT-1] === pat[0], "R2", "last bit is device0 row0/col0",
        got_seq[TOT-1], pat[0]);
    chk(hi_bad == 0 && lo_bad == 0, "R3", "high/low phase length errors", hi_bad + lo_bad, 0);
    chk(setup_bad == 0 && hold_bad == 0, "R3", "setup/hold errors", setup_bad + hold_bad, 0);
    chk(gap_meas == GAP, "R4", "gap before strobe", gap_meas, GAP);
    chk(pulse_meas == PUL, "R4", "strobe low width", pulse_meas, PUL);
    chk(sclk_in_pulse == 0, "R4", "serial clock during strobe", sclk_in_pulse, 0);
    chk(longint'(per_min) * CLK_PS >= 200000 && longint'(per_max) * CLK_PS <= 50000000, "R7",
        "serial clock period ps", longint'(per_min) * CLK_PS, 2 * DIV * CLK_PS);
    chk(tail_meas > 0 && longint'(tail_meas) * CLK_PS <= 64'd5_000_000_000, "R7",
        "last bit to strobe end ps", longint'(tail_meas) * CLK_PS, (DIV + GAP + PUL) * CLK_PS);
    if (disturb) begin
      repeat (4 * DIV) @(negedge clk);
      settle();
      chk(!busy_o && nbits == TOT, "R6", "no extra load from start while busy", nbits, TOT);
    end
  endtask

  task automatic t_random();
    t_load(mk_pat(32'h1234_5678), 1'b0);
  endtask

  task automatic t_boundary();
    logic [TOT-1:0] p;
    p = '0;
    p[TOT-1] = 1'b1; p[0] = 1'b1; p[G*G] = 1'b1; p[G*G-1] = 1'b1;
    t_load(p, 1'b0);
  endtask

  task automatic t_busy_ignore();
    t_load(mk_pat(32'hCAFE_0F0D), 1'b1);
  endtask

  initial begin
    t_reset();
    t_random();
    t_boundary();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog: actual busy %0d expected done", busy_o);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule